// File: doc/BRIEF.md
# DRAM Power-Down Entry/Exit Controller

This block sits inside a DDR SDRAM controller and owns the clock-enable pin and the command bus whenever the memory enters or leaves power-down. The scheduler asks for entry or exit. The block lowers clock enable only when no read or write burst is in flight, including its postamble. While the memory is powered down, the block drives NOP, and it also drives NOP in the cycle that clock enable returns high. It keeps normal commands blocked until the cycle after that exit NOP.

On entry, the block records which kind of power-down began. If every bank was idle at the entry edge, the mode is precharge power-down. If any bank held an open row, the mode is active power-down. The length of a power-down is limited by a programmable cycle count, so that refresh can still be serviced. When that count runs out, the block forces an exit and sends a one-cycle refresh-due pulse to the refresh logic.

The state machine has four states:
- `PD_RUN`: normal operation.
- `PD_PEND`: an entry request is waiting for a burst to finish.
- `PD_DOWN`: clock enable is low.
- `PD_EXIT`: clock enable is high with a NOP on the bus.

It has these transitions:
- RUN→DOWN: an entry request while no burst is active.
- RUN→PEND: an entry request while a burst is active.
- PEND→DOWN: the burst has completed.
- PEND→RUN: an exit request cancels the pending entry.
- DOWN→EXIT: an exit request, or expiry of the duration timer.
- EXIT→RUN: always, after one cycle.

Top module: `dram_pd_ctrl`

## Requirements
- R1: After reset `cke` is 1, and `cmd_nop`, `cmd_block`, `pd_active` and `refresh_due` are all 0.
- R2: An `enter_req` sampled in RUN with `burst_busy` low makes `cke` 0 and `pd_active` 1 in the next cycle.
- R3: An `enter_req` sampled with `burst_busy` high keeps `cke` at 1 and raises `cmd_block`. Power-down (`cke` 0) begins in the cycle after the first edge that samples `burst_busy` low.
- R4: `cke` never goes low in the cycle after a cycle in which both `cke` and `burst_busy` were high.
- R5: `pd_mode` is 0 (precharge power-down) when `all_banks_idle` was 1 at the entry edge, and 1 (active power-down) otherwise. It stays constant for the whole power-down.
- R6: While `cke` is 0, both `cmd_nop` and `cmd_block` are 1.
- R7: An `exit_req` sampled while powered down gives one cycle with `cke` 1, `cmd_nop` 1 and `cmd_block` 1. In the cycle after that, `cmd_block` and `cmd_nop` are 0.
- R8: With `max_pd_cycles` = M and M ≠ 0, power-down lasts at most M cycles. When it reaches M, the exit is forced and `refresh_due` is 1 for exactly the one exit-NOP cycle. M = 0 means there is no limit.
- R9: An `exit_req` sampled while an entry is pending returns the block to RUN in the next cycle, with `cke` 1 and `cmd_block` 0.
- R10: An `exit_req` sampled in RUN has no effect: `cke` stays 1 and `cmd_block` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter power-down |
| exit_req | input | 1 | Request to leave power-down, or to cancel a pending entry |
| burst_busy | input | 1 | A read or write burst, or its postamble, is in progress |
| all_banks_idle | input | 1 | No bank holds an open row |
| max_pd_cycles | input | CNT_W | Power-down duration limit in cycles; 0 means no limit |
| cke | output | 1 | Clock enable to the DRAM |
| cmd_nop | output | 1 | Forces NOP onto the command bus |
| cmd_block | output | 1 | Normal commands must not be issued |
| pd_active | output | 1 | Power-down is in effect |
| pd_mode | output | 1 | 0 = precharge power-down, 1 = active power-down |
| refresh_due | output | 1 | One-cycle pulse when the duration limit forced the exit |

## Verification
The assertions check the following on every cycle:
- Clock enable cannot fall after a cycle with an active burst.
- Every powered-down cycle carries a NOP and a block.
- Clock enable rises only together with a NOP, and commands are released one cycle later.
- The refresh-due pulse lasts a single cycle.
- The mode bit is stable during power-down.
- The dwell counter stays below the limit.

Only the bench's sweeps can show the following:
- The exact cycle counts: entry latency after bursts of different lengths, and forced-exit duration against request-driven exit.
- The mode chosen for each bank-idle value.
- The cancel and ignore cases.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;
    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_PEND = 2'd1,
        PD_DOWN = 2'd2,
        PD_EXIT = 2'd3
    } pd_state_e;
endpackage

// File: rtl/pd_dwell_timer.sv
module pd_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expire = run && (limit != '0) && (cnt_q == limit - 1'b1);

    // R8: the dwell count never reaches the limit while the limit is held steady
    assert_dwell_below_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0 && $stable(limit)) |-> (cnt_q < limit));
endmodule

// File: rtl/dram_pd_ctrl.sv
module dram_pd_ctrl
    import dram_pd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             exit_req,
    input  logic             burst_busy,
    input  logic             all_banks_idle,
    input  logic [CNT_W-1:0] max_pd_cycles,
    output logic             cke,
    output logic             cmd_nop,
    output logic             cmd_block,
    output logic             pd_active,
    output logic             pd_mode,
    output logic             refresh_due
);
    pd_state_e state_q, state_d;
    logic      expire;
    logic      mode_q;
    logic      refresh_q;

    pd_dwell_timer #(.CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == PD_DOWN),
        .limit  (max_pd_cycles),
        .expire (expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_RUN:  if (enter_req) state_d = burst_busy ? PD_PEND : PD_DOWN;
            PD_PEND: if (exit_req) state_d = PD_RUN;
                     else if (!burst_busy) state_d = PD_DOWN;
            PD_DOWN: if (exit_req || expire) state_d = PD_EXIT;
            PD_EXIT: state_d = PD_RUN;
            default: state_d = PD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PD_RUN;
            mode_q    <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            refresh_q <= (state_q == PD_DOWN) && expire;
            if (state_d == PD_DOWN && state_q != PD_DOWN)
                mode_q <= ~all_banks_idle;
        end
    end

    always_comb begin
        cke       = 1'b1;
        cmd_nop   = 1'b0;
        cmd_block = 1'b0;
        pd_active = 1'b0;
        unique case (state_q)
            PD_RUN:  ;
            PD_PEND: cmd_block = 1'b1;
            PD_DOWN: begin
                cke       = 1'b0;
                cmd_nop   = 1'b1;
                cmd_block = 1'b1;
                pd_active = 1'b1;
            end
            PD_EXIT: begin
                cmd_nop   = 1'b1;
                cmd_block = 1'b1;
            end
            default: ;
        endcase
    end

    assign pd_mode     = mode_q;
    assign refresh_due = refresh_q;

    assert_cke_hold_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && burst_busy) |=> cke);
    assert_nop_while_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_nop && cmd_block));
    assert_exit_with_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_nop && cmd_block));
    assert_release_after_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |=> !cmd_block);
    assert_refresh_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |=> !refresh_due);
    assert_refresh_on_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |-> (cke && $past(!cke)));
    assert_mode_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> $stable(pd_mode));
endmodule

// File: tb/dram_pd_ctrl_tb.sv
module dram_pd_ctrl_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enter_req, exit_req, burst_busy, all_banks_idle;
    logic [CW-1:0] max_pd_cycles;
    logic          cke, cmd_nop, cmd_block, pd_active, pd_mode, refresh_due;
    int            n_chk = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    dram_pd_ctrl #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .burst_busy(burst_busy), .all_banks_idle(all_banks_idle),
        .max_pd_cycles(max_pd_cycles), .cke(cke), .cmd_nop(cmd_nop),
        .cmd_block(cmd_block), .pd_active(pd_active), .pd_mode(pd_mode),
        .refresh_due(refresh_due)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int m, input int idle, input int busy, input int k);
        int n;
        int exp_len;
        int forced;
        max_pd_cycles  = CW'(m);
        all_banks_idle = idle[0];
        burst_busy     = (busy > 0);
        enter_req      = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        for (int i = 0; i < busy; i++) begin
            chk("R3 cke while pending", int'(cke), 1);
            chk("R3 block while pending", int'(cmd_block), 1);
            if (i == busy - 1) burst_busy = 1'b0;
            @(negedge clk);
        end
        chk("R2 cke low after entry", int'(cke), 0);
        chk("R2 pd_active", int'(pd_active), 1);
        chk("R5 mode", int'(pd_mode), idle ? 0 : 1);
        n = 0;
        while (cke == 1'b0 && n < 40) begin
            n++;
            chk("R6 nop while down", int'(cmd_nop && cmd_block), 1);
            chk("R5 mode held", int'(pd_mode), idle ? 0 : 1);
            if (n == k) exit_req = 1'b1;
            @(negedge clk);
            exit_req = 1'b0;
        end
        forced  = (m != 0 && m <= k) ? 1 : 0;
        exp_len = forced ? m : k;
        chk("R8 duration", n, exp_len);
        chk("R7 exit cke", int'(cke), 1);
        chk("R7 exit nop", int'(cmd_nop && cmd_block), 1);
        chk("R8 refresh_due", int'(refresh_due), forced);
        @(negedge clk);
        chk("R7 block released", int'(cmd_block), 0);
        chk("R7 nop released", int'(cmd_nop), 0);
        chk("R8 refresh pulse ended", int'(refresh_due), 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enter_req = 1'b0; exit_req = 1'b0; burst_busy = 1'b0;
        all_banks_idle = 1'b1; max_pd_cycles = '0;
        repeat (3) @(negedge clk);
        chk("R1 cke", int'(cke), 1);
        chk("R1 outputs low", int'(cmd_nop | cmd_block | pd_active | refresh_due), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: exit request in RUN is ignored
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R10 cke", int'(cke), 1);
        chk("R10 block", int'(cmd_block), 0);

        // R9: cancel a pending entry
        burst_busy = 1'b1; enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        chk("R3 pending block", int'(cmd_block), 1);
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0; burst_busy = 1'b0;
        chk("R9 cke", int'(cke), 1);
        chk("R9 block", int'(cmd_block), 0);
        @(negedge clk);
        chk("R9 stays run", int'(cke && !cmd_block), 1);

        for (int m = 0; m <= 4; m++)
            for (int idle = 0; idle <= 1; idle++)
                for (int b = 0; b <= 2; b++)
                    for (int k = 1; k <= 5; k++) begin
                        run_case(m, idle, b, k);
                        @(negedge clk);
                    end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule